// File: doc/BRIEF.md
# Serial I/O port expander

This block gives a host microcontroller twelve extra general-purpose lines over a four-wire serial link. The host drives a serial clock, an active-low select, a data bit and a strobe. The block returns one serial data bit. Two shift registers work side by side. A receive register collects the bits the host sends. A transmit register holds a snapshot of the twelve pin levels, and its contents go back to the host during the same clock sequence.

A strobe edge copies the receive register into an output latch, and that latch drives the pins. Every pin and the serial return line are open-drain: the block only ever pulls a line low or lets it go. A pin works as an input when its latch bit is 1, because the line is then released and an outside source sets its level. A pin works as an output when its latch bit is 0. No direction register exists. All host inputs are sampled on the fast system clock, and their edges are found by comparing each sample with the one before it. The host must hold each serial clock level for at least two system clock cycles, and the serial clock must idle low.

Bit 0 of every vector is the first pin and bit 11 is the last.

Top module: `sio_expander`

## Requirements
- R1: After a synchronous reset the output latch holds all ones, so no pin is pulled low (`pin_pull_o` = 0), and the serial return line is released (`sdo_pull_o` = 0).
- R2: When the select input goes low, the block captures the twelve pin levels into the transmit register. On the next cycle the return line shows the level of pin bit 0.
- R3: Each falling serial clock edge while selected moves the return line to the next higher pin bit. After the twelfth falling edge, ones have filled the transmit register and the line is released.
- R4: Each rising serial clock edge while selected shifts the data input into bit 11 of the receive register and moves the other bits one place toward bit 0. After twelve edges, the first bit sent sits in bit 0.
- R5: A rising edge on the strobe copies the receive register into the output latch, whether or not the block is selected. `pin_pull_o` is the bitwise inverse of the latch.
- R6: The output latch changes on no cycle other than the one after a strobe rising edge. A strobe held high or held low leaves the latch unchanged.
- R7: While the select input is high, the return line is released and the serial clock and data input have no effect on either shift register.
- R8: The word read back holds the external level for each pin whose latch bit is 1 and holds 0 for each pin the block pulls low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Host serial clock (idles low) |
| cs_n_i | input | 1 | Host select, active low |
| sdi_i | input | 1 | Host serial data into the block |
| set_i | input | 1 | Strobe; a rising edge loads the output latch |
| pin_in_i | input | 12 | Sampled level of each wired pin |
| pin_pull_o | output | 12 | 1 pulls the matching pin low, 0 releases it |
| sdo_pull_o | output | 1 | 1 pulls the serial return line low |

## Verification
The assertions check four things on every cycle. The return line is released while the block is deselected. The latch moves only after a strobe edge, and then it takes the receive register. A select edge loads the pin level into the return bit. Each serial rising edge lands the data bit in the top stage. Only the bench scenarios can show the word-level results: the bit order across a full or partial transfer, the fill that releases the line after twelve bits, and the wired-AND read-back of pins that the block and an outside driver share.

// File: rtl/sio_pkg.sv
package sio_pkg;
  parameter int unsigned SIO_WIDTH = 12;
  // positions of host controls inside the edge detector bank
  localparam int unsigned CTL_SCLK = 0;
  localparam int unsigned CTL_CSN  = 1;
  localparam int unsigned CTL_SET  = 2;
  localparam int unsigned CTL_N    = 3;
endpackage

// File: rtl/sio_edge_bank.sv
module sio_edge_bank #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= sig_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise_o[g] =  sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] &  prev_q[g];
  end
endmodule

// File: rtl/sio_rx_shift.sv
module sio_rx_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)           word_o <= '1;
    else if (shift_en) word_o <= {din, word_o[W-1:1]};
  end
endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         load_en,
  input  logic         shift_en,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] word_o,
  output logic         pull_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '1;
      pull_o <= 1'b0;
    end else if (!active) begin
      pull_o <= 1'b0;
    end else if (load_en) begin
      word_o <= pins_i;
      pull_o <= ~pins_i[0];
    end else if (shift_en) begin
      word_o <= {1'b1, word_o[W-1:1]};
      pull_o <= ~word_o[1];
    end
  end
endmodule

// File: rtl/sio_out_latch.sv
module sio_out_latch #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)          q_o <= '1;
    else if (load_en) q_o <= d_i;
  end
endmodule

// File: rtl/sio_expander.sv
module sio_expander
  import sio_pkg::*;
#(
  parameter int unsigned W = SIO_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         cs_n_i,
  input  logic         sdi_i,
  input  logic         set_i,
  input  logic [W-1:0] pin_in_i,
  output logic [W-1:0] pin_pull_o,
  output logic         sdo_pull_o
);
  localparam logic [CTL_N-1:0] CTL_RST = CTL_N'(1) << CTL_CSN;

  logic [CTL_N-1:0] ctl, rise, fall;
  logic [W-1:0]     rx_q, tx_q, latch_q;
  logic             sel;

  always_comb begin
    ctl           = '0;
    ctl[CTL_SCLK] = sclk_i;
    ctl[CTL_CSN]  = cs_n_i;
    ctl[CTL_SET]  = set_i;
  end

  assign sel = ~cs_n_i;

  sio_edge_bank #(.N(CTL_N), .RST_VAL(CTL_RST)) u_edges (
    .clk(clk), .rst(rst), .sig_i(ctl), .rise_o(rise), .fall_o(fall)
  );

  sio_rx_shift #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .shift_en(sel & rise[CTL_SCLK]),
    .din(sdi_i), .word_o(rx_q)
  );

  sio_tx_shift #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .active(sel), .load_en(fall[CTL_CSN]),
    .shift_en(fall[CTL_SCLK]), .pins_i(pin_in_i),
    .word_o(tx_q), .pull_o(sdo_pull_o)
  );

  sio_out_latch #(.W(W)) u_latch (
    .clk(clk), .rst(rst), .load_en(rise[CTL_SET]),
    .d_i(rx_q), .q_o(latch_q)
  );

  assign pin_pull_o = ~latch_q;
endmodule

// File: rtl/sio_expander_chk.sv
module sio_expander_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         sclk_i,
  input logic         cs_n_i,
  input logic         sdi_i,
  input logic         set_i,
  input logic [W-1:0] pin_in_i,
  input logic [W-1:0] pin_pull_o,
  input logic         sdo_pull_o,
  input logic [W-1:0] rx_q,
  input logic [W-1:0] tx_q
);
  logic sclk_p, csn_p, set_p;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= 1'b0; csn_p <= 1'b1; set_p <= 1'b0;
    end else begin
      sclk_p <= sclk_i; csn_p <= cs_n_i; set_p <= set_i;
    end
  end

  assert_released_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !sdo_pull_o);

  assert_regs_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> ($stable(rx_q) && $stable(tx_q)));

  assert_strobe_loads_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (set_i && !set_p) |=> (pin_pull_o == ~$past(rx_q)));

  assert_latch_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !(set_i && !set_p) |=> $stable(pin_pull_o));

  assert_capture_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_i && csn_p) |=> (sdo_pull_o == !$past(pin_in_i[0])));

  assert_shift_in_top_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_i && sclk_i && !sclk_p) |=> (rx_q[W-1] == $past(sdi_i)));
endmodule

bind sio_expander sio_expander_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdi_i(sdi_i),
  .set_i(set_i), .pin_in_i(pin_in_i), .pin_pull_o(pin_pull_o),
  .sdo_pull_o(sdo_pull_o), .rx_q(rx_q), .tx_q(tx_q)
);

// File: tb/sio_expander_tb.sv
`timescale 1ns/1ps
module sio_expander_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst, sclk, cs_n, sdi, set;
  logic [W-1:0] ext, pin_lvl, pin_pull;
  logic sdo_pull;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] exp_latch, rx_model;

  always #2.5 clk = ~clk;

  assign pin_lvl = ext & ~pin_pull;

  sio_expander #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .set_i(set), .pin_in_i(pin_lvl), .pin_pull_o(pin_pull), .sdo_pull_o(sdo_pull)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    set = 1'b1; wait_n(2);
    set = 1'b0; wait_n(1);
    exp_latch = rx_model;
  endtask

  // full or partial transfer; word bit 0 sent first
  task automatic xfer(input logic [W-1:0] word, input int nbits);
    logic [W-1:0] cap, got, mask;
    cap = ext & exp_latch;
    got = '0;
    cs_n = 1'b0; wait_n(2);
    for (int i = 0; i < nbits; i++) begin
      got[i] = ~sdo_pull;
      sdi = word[i];
      sclk = 1'b1; wait_n(2);
      sclk = 1'b0; wait_n(2);
      rx_model = {word[i], rx_model[W-1:1]};
    end
    if (nbits == W)
      check(sdo_pull == 1'b0, "R3 released after last bit", 32'(sdo_pull), 0);
    cs_n = 1'b1; wait_n(1);
    mask = W'((1 << nbits) - 1);
    check((got & mask) == (cap & mask), "R2/R3/R8 read-back word",
          32'(got & mask), 32'(cap & mask));
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] w;
    int nb;
    void'($urandom(32'h5eed));
    rst = 1; sclk = 0; cs_n = 1; sdi = 0; set = 0; ext = '1;
    exp_latch = '1; rx_model = '1;
    wait_n(3); rst = 0; wait_n(1);

    check(pin_pull == '0, "R1 pins released", 32'(pin_pull), 0);
    check(sdo_pull == 1'b0, "R1 return line released", 32'(sdo_pull), 0);

    xfer(12'hA5C, W);
    check(pin_pull == '0, "R6 latch unchanged without strobe", 32'(pin_pull), 0);
    strobe();
    check(pin_pull == ~12'hA5C, "R5 strobe loads latch", 32'(pin_pull), 32'(~12'hA5C));

    ext = 12'h3F0;
    xfer(12'h123, W);   // R8: read-back must be 3F0 & A5C
    set = 1'b1; wait_n(2); exp_latch = rx_model;
    check(pin_pull == ~12'h123, "R5 latch from edge", 32'(pin_pull), 32'(~12'h123));
    xfer(12'h777, W);
    check(pin_pull == ~12'h123, "R6 strobe held high", 32'(pin_pull), 32'(~12'h123));
    set = 1'b0; wait_n(2);
    check(pin_pull == ~12'h123, "R6 strobe falling", 32'(pin_pull), 32'(~12'h123));
    strobe();
    check(pin_pull == ~12'h777, "R5 second load", 32'(pin_pull), 32'(~12'h777));

    // R7: serial clock and data while deselected
    for (int i = 0; i < 6; i++) begin
      sdi = 1'(i); sclk = 1'b1; wait_n(2);
      check(sdo_pull == 1'b0, "R7 line released when idle", 32'(sdo_pull), 0);
      sclk = 1'b0; wait_n(2);
    end
    rx_model = 12'h777;
    strobe();
    check(pin_pull == ~12'h777, "R7 receive register held", 32'(pin_pull), 32'(~12'h777));

    // R4: partial transfer leaves older bits shifted toward bit 0
    ext = '1;
    xfer(12'h00A, 4);
    strobe();
    check(pin_pull == ~rx_model, "R4 partial shift", 32'(pin_pull), 32'(~rx_model));

    // directed: all pins pulled low reads all zero (R8)
    xfer(12'h000, W);
    strobe();
    xfer(12'hFFF, W);
    strobe();
    check(pin_pull == '0, "R4 all ones word", 32'(pin_pull), 0);

    for (int k = 0; k < 20; k++) begin
      ext = W'($urandom);
      w   = W'($urandom);
      nb  = ($urandom % 4 == 0) ? int'($urandom % W) + 1 : W;
      xfer(w, nb);
      strobe();
      check(pin_pull == ~rx_model, "R4/R5 random transfer", 32'(pin_pull), 32'(~rx_model));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule